// File: doc/BRIEF.md
# Iterative odd-even transposition sorter

The block keeps a small set of unsigned values (six 4-bit values by default) in a register bank and puts them in ascending order in place. On each clock it runs one compare-exchange step and then switches phase. In the even phase it looks at the pairs that start at an even index. In the odd phase it looks at the pairs that start at an odd index. A pair that is out of order swaps its two values. The number of steps depends on how the data arrives. A set that is already in order needs none. With N elements, at most N steps are needed.

A sortedness detector compares every adjacent pair and raises `done` when no pair is out of order. A producer presents a new set on `din` and raises `ready`. The set is taken on the first clock where `ready` and `done` are both high, so a new set never replaces one that is still being sorted. The bank contents are always visible on `dout`. Element i sits at bits [i*W +: W] of both `din` and `dout`. Index 0 holds the smallest value.

Top module: `oets_sorter`

## Requirements
- R1: While the synchronous active-high `rst` is high, the bank is cleared to zero and the phase is set to even. On the first sample after reset is released, `dout` is all zeros and `done` is high.
- R2: On a clock edge where `ready` and `done` are both high, the bank loads `din`. Element i is taken from bits [i*W +: W], and one cycle later `dout` equals that `din`.
- R3: While `done` is low, `ready` and `din` are ignored: the sort in progress continues unchanged.
- R4: The first step after a load is an even step. Each pair (0,1), (2,3), (4,5) whose lower-index value is greater than its upper-index value exchanges its two values. Pairs that are not out of order keep their values.
- R5: The step after an even step is an odd step. Pairs (1,2) and (3,4) exchange their values when out of order, and elements 0 and 5 hold their values.
- R6: `done` is high exactly when, for every i, element i of `dout` is less than or equal to element i+1.
- R7: When `done` rises, the bank holds an ascending permutation of the loaded set, with equal values left in place. This happens no more than N clock cycles after the load.
- R8: While `done` is high and `ready` is low, `dout` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | input | 1 | Producer has a new set on `din` |
| din | input | N*W | New set; element i at bits [i*W +: W] |
| dout | output | N*W | Bank contents; element i at bits [i*W +: W] |
| done | output | 1 | No adjacent pair is out of order |

## Verification
The sort is tried with the following sets:
- A fully reversed set, which needs the most steps.
- An already ordered set, which must finish with no step at all.
- Sets with duplicates and an all-equal set, which show whether equal values are left alone.
- A set alternating between the extreme values, which tests the comparator at its widest spread.
- A run of pseudo-random sets.

For the first few sets, the exact bank after the even step and after the odd step is compared, which tells a wrong pairing or a wrong phase order apart from a merely slow sort. Driving `ready` with unrelated data during a sort shows whether loading is gated by `done`. A quiet interval after the last sort shows whether the bank holds once it is sorted.

// File: rtl/oets_sorter.sv
module oets_sorter #(
  parameter int N = 6,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ready,
  input  logic [N*W-1:0] din,
  output logic [N*W-1:0] dout,
  output logic         done
);
  localparam int SW = W + $clog2(N) + 1;

  logic [W-1:0] v  [N];
  logic [W-1:0] nx [N];
  logic [N-2:0] gt, sw;
  logic         odd;
  logic         load;

  assign load = ready & done;
  assign done = ~|gt;

  for (genvar j = 0; j < N - 1; j++) begin : g_pair
    assign gt[j] = v[j] > v[j+1];
    assign sw[j] = gt[j] && ((((j % 2) == 1) ? 1'b1 : 1'b0) == odd);
  end

  for (genvar i = 0; i < N; i++) begin : g_elem
    if (i == 0) begin : g_first
      assign nx[i] = sw[0] ? v[1] : v[0];
    end else if (i == N - 1) begin : g_last
      assign nx[i] = sw[N-2] ? v[N-2] : v[i];
    end else begin : g_mid
      assign nx[i] = sw[i] ? v[i+1] : (sw[i-1] ? v[i-1] : v[i]);
    end
    assign dout[i*W +: W] = v[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) v[i] <= '0;
      odd <= 1'b0;
    end else if (load) begin
      for (int i = 0; i < N; i++) v[i] <= din[i*W +: W];
      odd <= 1'b0;
    end else begin
      if (!done)
        for (int i = 0; i < N; i++) v[i] <= nx[i];
      odd <= ~odd;
    end
  end

  logic [SW-1:0] sum;
  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) sum = sum + SW'(v[i]);
  end

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == '0) && done);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (ready && done) |=> dout == $past(din));

  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    !done |=> sum == $past(sum));

  p_odd_ends_r5: assert property (@(posedge clk) disable iff (rst)
    (!done && odd) |=> $stable(dout[W-1:0]) && $stable(dout[N*W-1 -: W]));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !ready) |=> $stable(dout));
endmodule

// File: tb/oets_sorter_tb_top.sv
`timescale 1ns/1ps
module oets_sorter_tb_top;
  localparam int N = 6;
  localparam int W = 4;
  localparam int L = N * W;

  logic clk = 1'b0;
  logic rst, ready, done;
  logic [L-1:0] din, dout;

  int checks = 0, failures = 0;
  bit ended = 0;
  logic [L-1:0] q [$];

  always #2.5 clk = ~clk;

  oets_sorter #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .ready(ready), .din(din), .dout(dout), .done(done));

  function automatic logic [W-1:0] el(logic [L-1:0] x, int i);
    return x[i*W +: W];
  endfunction

  function automatic logic [L-1:0] step(logic [L-1:0] x, int start);
    logic [L-1:0] y = x;
    for (int j = start; j < N - 1; j += 2)
      if (el(y, j) > el(y, j+1)) begin
        logic [W-1:0] t = el(y, j);
        y[j*W +: W] = el(y, j+1);
        y[(j+1)*W +: W] = t;
      end
    return y;
  endfunction

  function automatic bit sorted_ok(logic [L-1:0] x);
    for (int j = 0; j < N - 1; j++) if (el(x, j) > el(x, j+1)) return 0;
    return 1;
  endfunction

  function automatic logic [L-1:0] sort_ref(logic [L-1:0] x);
    logic [L-1:0] y = x;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N - 1 - a; b++)
        if (el(y, b) > el(y, b+1)) begin
          logic [W-1:0] t = el(y, b);
          y[b*W +: W] = el(y, b+1);
          y[(b+1)*W +: W] = t;
        end
    return y;
  endfunction

  function automatic logic [L-1:0] pack6(int a, int b, int c, int d, int e, int f);
    return {W'(f), W'(e), W'(d), W'(c), W'(b), W'(a)};
  endfunction

  task automatic chk(string req, logic [L-1:0] act, logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic run_set(logic [L-1:0] v, bit directed, bit noise);
    logic [L-1:0] e;
    wait_done();
    din = v; ready = 1'b1; q.push_back(sort_ref(v));
    @(negedge clk);
    ready = 1'b0;
    chk("R2", dout, v);
    chk("R6", L'(done), L'(sorted_ok(v)));
    if (noise && !sorted_ok(v)) begin
      ready = 1'b1; din = ~v;
    end
    if (directed && !sorted_ok(v)) begin
      e = step(v, 0);
      @(negedge clk);
      ready = 1'b0;
      chk(noise ? "R3" : "R4", dout, e);
      chk("R6", L'(done), L'(sorted_ok(e)));
      if (!sorted_ok(e)) begin
        @(negedge clk);
        chk("R5", dout, step(e, 1));
      end
    end
  endtask

  initial begin : monitor
    bit pend = 0;
    int cyc = 0;
    logic [L-1:0] exp;
    forever begin
      @(negedge clk); #1.25;
      if (rst !== 1'b0) begin pend = 0; continue; end
      if (pend) begin
        if (done === 1'b1) begin
          exp = q.pop_front();
          chk("R7", dout, exp);
          checks++;
          if (cyc > N) begin
            failures++;
            $display("FAIL R7 steps got %0d expected at most %0d", cyc, N);
          end
          pend = 0;
        end else cyc++;
      end
      if (ready === 1'b1 && done === 1'b1) begin pend = 1; cyc = 0; end
    end
  end

  initial begin : watchdog
    #(100000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : driver
    logic [L-1:0] held;
    logic [15:0] lfsr = 16'hACE1;
    rst = 1'b1; ready = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", dout, '0);
    chk("R1", L'(done), L'(1));

    run_set(pack6(15, 12, 9, 6, 3, 0), 1, 0);
    run_set(pack6(1, 2, 3, 4, 5, 6), 1, 0);
    run_set(pack6(7, 7, 2, 2, 9, 0), 1, 0);
    run_set(pack6(5, 5, 5, 5, 5, 5), 1, 0);
    run_set(pack6(15, 0, 15, 0, 15, 0), 1, 0);
    run_set(pack6(0, 1, 2, 3, 5, 4), 1, 0);
    run_set(pack6(9, 8, 7, 6, 5, 4), 1, 1);
    for (int k = 0; k < 30; k++) begin
      logic [L-1:0] r;
      for (int b = 0; b < L; b++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        r[b] = lfsr[0];
      end
      run_set(r, k < 5, k == 7);
    end

    wait_done();
    held = dout;
    din = ~held;
    repeat (5) begin
      @(negedge clk);
      chk("R8", dout, held);
      chk("R6", L'(done), L'(1));
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule